// File: doc/BRIEF.md
# Video Memory Mirroring Decoder

This block decodes accesses to the upper part of a tile-based video processor's 14-bit address space, from 0x2000 to 0x3FFF. Each access carries an address, a read or write strobe, write data and a 3-bit mirroring mode. The block sends it to one of two memories held inside the block. The first is a 2 KB nametable store made of two physical 1 KB banks. The second is a 32-entry palette store. Reads come back one cycle later.

The nametable window holds four logical 1 KB screens. The mirroring mode decides which physical bank each screen lands on. The span 0x3000–0x3EFF is an image of 0x2000–0x2EFF. Palette space repeats every 32 bytes. The four transparent entries of the sprite half share storage with their counterparts in the background half. Any access below 0x2000 belongs to pattern memory, which lives outside this block. Such an access is flagged as unmapped and touches no storage.

Top module: `vram_mirror_decoder`

## Requirements
- R1: In mode 0 (horizontal), logical screen t = addr[11:10] maps to physical bank t[1], and the byte offset addr[9:0] is kept, so the physical index is bank*0x400 + offset.
- R2: In mode 1 (vertical), logical screen t maps to physical bank t[0].
- R3: In mode 2 (four-screen), logical screen t maps to bank t. With two physical banks, screens 2 and 3 wrap onto banks 0 and 1.
- R4: Mode 3 sends every screen to bank 0 and mode 4 sends every screen to bank 1. Mode codes 5 to 7 behave like mode 3.
- R5: An address in 0x3000–0x3EFF reads and writes the same byte as that address minus 0x1000.
- R6: Addresses 0x3F00–0x3FFF select the palette entry given by addr[4:0].
- R7: Palette entries 0x10, 0x14, 0x18 and 0x1C, after masking to 5 bits, are redirected to entries 0x00, 0x04, 0x08 and 0x0C. This holds for both reads and writes.
- R8: A read strobe without a write strobe raises rdValid and presents the data on rdData in the following cycle. rdData holds its value in cycles that follow no read.
- R9: A write commits on the clock edge where wrStb is high. If rdStb and wrStb are high together, the write is performed and no read is returned.
- R10: An access below 0x2000 raises unmapped in the following cycle. A read there returns 0 and a write there changes no storage.
- R11: After reset, rdData is 0, and rdValid and unmapped are low.
- R12: The mirroring mode is applied per access, so a mode change takes effect on the very next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 14 | Access address |
| rdStb | input | 1 | Read request |
| wrStb | input | 1 | Write request |
| wrData | input | 8 | Write data |
| mirrorMode | input | 3 | Mirroring mode code, 0 to 4 (5 to 7 act as 3) |
| rdData | output | 8 | Read data, one cycle after the request |
| rdValid | output | 1 | rdData carries a fresh read result |
| unmapped | output | 1 | Previous access fell below 0x2000 |

## Verification
The whole nametable is first filled through four-screen mode with a distinct byte per location. Then every mode in turn writes a sparse lattice and reads back a denser lattice across the whole 0x2000–0x3EFF window. The denser lattice includes the 0x3000 image, so a wrong bank choice or a wrong screen/offset split shows up as a byte from another location. All 256 palette addresses are read back after writes made through the aliased entries, including writes from the upper mirrors, which separates the 5-bit masking from the transparent-entry redirection. Targeted sequences cover the rest: a mode switch between a write and a read, simultaneous read and write strobes, and unmapped accesses followed by readback of the locations they would corrupt if decoded wrongly.

// File: rtl/vmd_pkg.sv
package vmd_pkg;

  localparam logic [2:0] MODE_HORZ = 3'd0;
  localparam logic [2:0] MODE_VERT = 3'd1;
  localparam logic [2:0] MODE_QUAD = 3'd2;
  localparam logic [2:0] MODE_LOW  = 3'd3;
  localparam logic [2:0] MODE_HIGH = 3'd4;

  // strobes from decode control to the storage datapath
  typedef struct packed {
    logic ntWr;
    logic ntRd;
    logic palWr;
    logic palRd;
    logic rdReq;
    logic miss;
  } acc_s;

  // logical screen (0..3) to logical bank (0..3) per mirroring mode
  function automatic logic [1:0] bankOf(input logic [2:0] mode, input logic [1:0] tbl);
    case (mode)
      MODE_HORZ: return {1'b0, tbl[1]};
      MODE_VERT: return {1'b0, tbl[0]};
      MODE_QUAD: return tbl;
      MODE_HIGH: return 2'd1;
      default:   return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/vmd_ctrl.sv
module vmd_ctrl
  import vmd_pkg::*;
#(
  parameter int NT_BANKS    = 2,
  parameter int BANK_BYTES  = 1024,
  parameter int PAL_ENTRIES = 32,
  localparam int BANK_W     = (NT_BANKS > 1) ? $clog2(NT_BANKS) : 1,
  localparam int OFF_W      = $clog2(BANK_BYTES),
  localparam int NT_IDX_W   = BANK_W + OFF_W,
  localparam int PAL_W      = $clog2(PAL_ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [13:0]         addr,
  input  logic                rdStb,
  input  logic                wrStb,
  input  logic [2:0]          mirrorMode,
  output acc_s                acc,
  output logic [NT_IDX_W-1:0] ntIdx,
  output logic [PAL_W-1:0]    palIdx
);

  logic       isPal, isNt, anyStb;
  logic [1:0] logBank;
  logic [1:0] screen;

  always_comb begin
    anyStb  = rdStb | wrStb;
    isPal   = (addr[13:8] == 6'h3F);
    isNt    = addr[13] & ~isPal;
    screen  = addr[OFF_W+1:OFF_W];
    logBank = bankOf(mirrorMode, screen);
    // banks beyond the physical count wrap (power-of-two modulo)
    ntIdx   = {logBank[BANK_W-1:0], addr[OFF_W-1:0]};

    palIdx = addr[PAL_W-1:0];
    if (palIdx[PAL_W-1] && palIdx[1:0] == 2'b00)
      palIdx[PAL_W-1] = 1'b0;

    acc.rdReq = rdStb & ~wrStb;
    acc.ntWr  = wrStb & isNt;
    acc.palWr = wrStb & isPal;
    acc.ntRd  = acc.rdReq & isNt;
    acc.palRd = acc.rdReq & isPal;
    acc.miss  = anyStb & ~addr[13];
  end

  // R7: no palette access may land on a transparent sprite slot
  assert_pal_alias_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.palWr || acc.palRd) |-> !(palIdx[PAL_W-1] && palIdx[1:0] == 2'b00));

  // R4: the single-high mode always reaches bank 1
  assert_single_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc.ntWr || acc.ntRd) && mirrorMode == MODE_HIGH) |-> (ntIdx[NT_IDX_W-1:OFF_W] == 1));

endmodule

// File: rtl/vmd_data.sv
module vmd_data
  import vmd_pkg::*;
#(
  parameter int NT_BANKS    = 2,
  parameter int BANK_BYTES  = 1024,
  parameter int PAL_ENTRIES = 32,
  localparam int BANK_W     = (NT_BANKS > 1) ? $clog2(NT_BANKS) : 1,
  localparam int OFF_W      = $clog2(BANK_BYTES),
  localparam int NT_IDX_W   = BANK_W + OFF_W,
  localparam int NT_DEPTH   = NT_BANKS * BANK_BYTES,
  localparam int PAL_W      = $clog2(PAL_ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  acc_s                acc,
  input  logic [NT_IDX_W-1:0] ntIdx,
  input  logic [PAL_W-1:0]    palIdx,
  input  logic [7:0]          wrData,
  output logic [7:0]          rdData,
  output logic                rdValid,
  output logic                unmapped
);

  logic [7:0] ntMem  [NT_DEPTH];
  logic [7:0] palMem [PAL_ENTRIES];

  always_ff @(posedge clk) begin
    if (acc.ntWr)  ntMem[ntIdx]   <= wrData;
    if (acc.palWr) palMem[palIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdData   <= '0;
      rdValid  <= 1'b0;
      unmapped <= 1'b0;
    end else begin
      rdValid  <= acc.rdReq;
      unmapped <= acc.miss;
      if (acc.ntRd)       rdData <= ntMem[ntIdx];
      else if (acc.palRd) rdData <= palMem[palIdx];
      else if (acc.rdReq) rdData <= '0;
    end
  end

  // R8: read data only moves after a read request
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc.rdReq |=> $stable(rdData));

endmodule

// File: rtl/vram_mirror_decoder.sv
module vram_mirror_decoder
  import vmd_pkg::*;
#(
  parameter int NT_BANKS    = 2,
  parameter int BANK_BYTES  = 1024,
  parameter int PAL_ENTRIES = 32,
  localparam int BANK_W     = (NT_BANKS > 1) ? $clog2(NT_BANKS) : 1,
  localparam int OFF_W      = $clog2(BANK_BYTES),
  localparam int NT_IDX_W   = BANK_W + OFF_W,
  localparam int PAL_W      = $clog2(PAL_ENTRIES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [13:0] addr,
  input  logic        rdStb,
  input  logic        wrStb,
  input  logic [7:0]  wrData,
  input  logic [2:0]  mirrorMode,
  output logic [7:0]  rdData,
  output logic        rdValid,
  output logic        unmapped
);

  acc_s                acc;
  logic [NT_IDX_W-1:0] ntIdx;
  logic [PAL_W-1:0]    palIdx;

  vmd_ctrl #(.NT_BANKS(NT_BANKS), .BANK_BYTES(BANK_BYTES), .PAL_ENTRIES(PAL_ENTRIES)) uCtrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rdStb(rdStb), .wrStb(wrStb),
    .mirrorMode(mirrorMode), .acc(acc), .ntIdx(ntIdx), .palIdx(palIdx)
  );

  vmd_data #(.NT_BANKS(NT_BANKS), .BANK_BYTES(BANK_BYTES), .PAL_ENTRIES(PAL_ENTRIES)) uData (
    .clk(clk), .rst_n(rst_n), .acc(acc), .ntIdx(ntIdx), .palIdx(palIdx),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .unmapped(unmapped)
  );

  // R8: a lone read is answered in the next cycle
  assert_rd_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && !wrStb) |=> rdValid);

  // R9: no read result without a lone read request
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdStb && !wrStb) |=> !rdValid);

  // R10: accesses below the window are flagged
  assert_unmapped_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdStb || wrStb) && addr < 14'h2000) |=> unmapped);

  // R10: unmapped reads return zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStb && !wrStb && addr < 14'h2000) |=> (rdData == 8'h00));

endmodule

// File: tb/sim_vram_mirror_decoder.sv
`timescale 1ns/1ps
module sim_vram_mirror_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] addr = '0;
  logic        rdStb = 1'b0;
  logic        wrStb = 1'b0;
  logic [7:0]  wrData = '0;
  logic [2:0]  mirrorMode = '0;
  logic [7:0]  rdData;
  logic        rdValid;
  logic        unmapped;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] ntModel  [2048];
  logic [7:0] palModel [32];

  always #2.5 clk = ~clk;

  vram_mirror_decoder u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rdStb(rdStb), .wrStb(wrStb),
    .wrData(wrData), .mirrorMode(mirrorMode), .rdData(rdData),
    .rdValid(rdValid), .unmapped(unmapped)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int ntPhys(input int a, input int m);
    int t, off, b;
    if (a >= 'h3000) a = a - 'h1000;
    t   = (a - 'h2000) / 'h400;
    off = (a - 'h2000) % 'h400;
    case (m)
      0: b = t / 2;
      1: b = t % 2;
      2: b = t % 2;
      4: b = 1;
      default: b = 0;
    endcase
    return b * 'h400 + off;
  endfunction

  function automatic int palPhys(input int a);
    int p;
    p = (a - 'h3F00) % 32;
    if (p == 'h10 || p == 'h14 || p == 'h18 || p == 'h1C) p = p - 'h10;
    return p;
  endfunction

  function automatic string modeTag(input int a, input int m);
    if (a >= 'h3000) return "R5";
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic doWrite(input int a, input int m, input int d);
    @(negedge clk);
    addr = 14'(a); mirrorMode = 3'(m); wrData = 8'(d); wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
    if (a >= 'h3F00) palModel[palPhys(a)] = 8'(d);
    else if (a >= 'h2000) ntModel[ntPhys(a, m)] = 8'(d);
  endtask

  task automatic doRead(input int a, input int m, output int d);
    @(negedge clk);
    addr = 14'(a); mirrorMode = 3'(m); rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0;
    d = int'(rdData);
  endtask

  task automatic readCheck(input int a, input int m, input string req);
    int d;
    doRead(a, m, d);
    if (a >= 'h3F00) check(req, d, int'(palModel[palPhys(a)]));
    else check(req, d, int'(ntModel[ntPhys(a, m)]));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11 rdData", int'(rdData), 0);
    check("R11 rdValid", int'(rdValid), 0);
    check("R11 unmapped", int'(unmapped), 0);

    // fill whole nametable store through four-screen mode (R3)
    for (int a = 'h2000; a < 'h2800; a++) doWrite(a, 2, (a * 5 + (a >> 8)) & 'hFF);
    // fill palette, aliased slots last written through low entries
    for (int p = 'h3F1F; p >= 'h3F00; p--) doWrite(p, 0, (p * 11 + 3) & 'hFF);

    // R8: latency and valid strobe
    doRead('h2005, 2, d);
    check("R8 value", d, int'(ntModel['h005]));
    check("R8 rdValid", int'(rdValid), 1);
    @(negedge clk);
    check("R8 rdValid drop", int'(rdValid), 0);
    check("R8 hold", int'(rdData), int'(ntModel['h005]));

    // per-mode sweeps (R1..R5); mode 5 covers the code 5..7 rule
    for (int m = 0; m <= 5; m++) begin
      for (int a = 'h2000 + m; a < 'h3000; a += 23) doWrite(a, m, (a * 3) ^ (m * 'h55) & 'hFF);
      for (int a = 'h2000 + m; a < 'h3F00; a += 7) readCheck(a, m, modeTag(a, m));
    end
    // writes through the 0x3000 image (R5)
    for (int a = 'h3001; a < 'h3F00; a += 101) doWrite(a, 1, a & 'hFF);
    for (int a = 'h2001; a < 'h2F00; a += 101) readCheck(a, 1, "R5");

    // R7: writes through aliased entries and upper mirrors
    doWrite('h3F10, 0, 'hA1);
    doWrite('h3F34, 0, 'hA2);
    doWrite('h3F58, 0, 'hA3);
    doWrite('h3F3C, 0, 'hA4);
    readCheck('h3F00, 0, "R7");
    readCheck('h3F04, 0, "R7");
    readCheck('h3F08, 0, "R7");
    readCheck('h3F0C, 0, "R7");
    doWrite('h3F1D, 0, 'h5D);
    readCheck('h3F0D, 0, "R7");
    readCheck('h3F1D, 0, "R7");
    // R6: full palette window
    for (int a = 'h3F00; a < 'h4000; a++) readCheck(a, 3, "R6");

    // R12: mode switch between consecutive accesses
    doWrite('h2000, 3, 'h3C);
    readCheck('h2000, 4, "R12");
    doRead('h2000, 3, d);
    check("R12 back", d, 'h3C);
    doWrite('h2C10, 0, 'h77);
    readCheck('h2410, 1, "R12");
    readCheck('h2810, 0, "R12");

    // R9: simultaneous strobes
    @(negedge clk);
    addr = 14'h2001; mirrorMode = 3'd0; wrData = 8'hE7; rdStb = 1'b1; wrStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0; wrStb = 1'b0;
    ntModel[ntPhys('h2001, 0)] = 8'hE7;
    check("R9 no rdValid", int'(rdValid), 0);
    readCheck('h2001, 0, "R9");

    // R10: unmapped region
    doWrite('h0800, 0, 'hEE);
    check("R10 flag wr", int'(unmapped), 1);
    doWrite('h1F00, 0, 'hEE);
    doRead('h1234, 0, d);
    check("R10 zero", d, 0);
    check("R10 flag rd", int'(unmapped), 1);
    check("R10 rdValid", int'(rdValid), 1);
    readCheck('h2000, 0, "R10");
    check("R10 flag clear", int'(unmapped), 0);
    readCheck('h2800, 0, "R10");
    readCheck('h2300, 1, "R10");
    readCheck('h2700, 1, "R10");
    readCheck('h3F00, 0, "R10");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule